// File: doc/BRIEF.md
# Variable-Latency Multiply/Divide Unit

This block is a 32-bit integer multiply and divide engine that keeps its results in two private registers, HI and LO. A command is launched with a one-cycle start pulse carrying an operation code and two operands, `rs` and `rt`. The result is computed up front and held back until a cycle counter expires. This reproduces the timing of a unit whose multiply cost depends on the size of `rs` and whose divide cost is constant.

A consumer reads HI and LO through a read-enable input. While an operation is outstanding, a read raises a stall output and holds that read until the result lands. Work that does not touch HI/LO proceeds with no penalty. Divide-by-zero and the one signed overflow case return fixed values and never trap. A new command issued while the unit is busy abandons the one in flight.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy_o` and `stall_o` are 0 and `hi_o` and `lo_o` read 0.
- R2: Operation codes are 0 = unsigned multiply, 1 = signed multiply, 2 = unsigned divide and 3 = signed divide. An unsigned multiply has latency 6 when rs ≤ 000007FFh, 9 when rs ≤ 000FFFFFh, and 13 otherwise. Latency L means that a read held from the cycle after the start cycle sees `stall_o` high for L−1 cycles.
- R3: A signed multiply has latency 6 when rs lies in 0..000007FFh or FFFFF800h..FFFFFFFFh. It has latency 9 for any other rs in 0..000FFFFFh or FFF00000h..FFFFFFFFh, and latency 13 for every remaining rs.
- R4: Both divides have latency 36, whatever the operand values.
- R5: A multiply writes the upper 32 bits of the 64-bit product to HI and the lower 32 bits to LO, treating the operands as unsigned for code 0 and as two's complement for code 1.
- R6: A divide with a nonzero divisor writes the quotient to LO and the remainder to HI. A signed quotient truncates toward zero, and the remainder takes the sign of rs.
- R7: Division by zero raises no error. It returns HI = rs, and LO = FFFFFFFFh, except that a signed divide of a negative rs returns LO = 00000001h.
- R8: A signed divide of 80000000h by FFFFFFFFh returns LO = 80000000h and HI = 0.
- R9: A read during an operation holds `stall_o` high until the last busy cycle. In that cycle `stall_o` is 0 and `hi_o`/`lo_o` already show the new result.
- R10: A start pulse while busy abandons the current operation. Latency and result then follow the new command only.
- R11: HI and LO keep their value between operations. A read while idle never stalls and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle command launch |
| op_i | input | 2 | Operation code (see R2) |
| rs_i | input | 32 | First operand (multiplicand / dividend) |
| rt_i | input | 32 | Second operand (multiplier / divisor) |
| rd_en_i | input | 1 | HI/LO read request |
| busy_o | output | 1 | An operation is outstanding |
| stall_o | output | 1 | Read request must wait |
| hi_o | output | 32 | HI read data |
| lo_o | output | 32 | LO read data |

## Verification
The assertions assume that `op_i`, `rs_i` and `rt_i` are meaningful only in a cycle with `start_i` high. They also assume that reset is held long enough for the counter and result registers to clear. The stimulus changes operands only on start cycles and drives every input half a period away from the clock edge. It raises `rd_en_i` only after the start pulse has been taken, so a granted read always marks the final busy cycle or an idle unit. Corner operands sit on each boundary of the latency ranges and on the zero-divisor and overflow cases.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   // Bit 0 selects two's complement operands, bit 1 selects divide.
   typedef enum logic [1:0] {
      MD_MUL_U = 2'd0,
      MD_MUL_S = 2'd1,
      MD_DIV_U = 2'd2,
      MD_DIV_S = 2'd3
   } md_op_e;

   function automatic logic op_is_div(input logic [1:0] op);
      return op[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] op);
      return op[0];
   endfunction

endpackage

// File: rtl/muldiv_latency.sv
module muldiv_latency
   import muldiv_pkg::*;
#(
   parameter int W         = 32,
   parameter int FAST_BITS = 11,
   parameter int MED_BITS  = 20,
   parameter int FAST_LAT  = 6,
   parameter int MED_LAT   = 9,
   parameter int SLOW_LAT  = 13,
   parameter int DIV_LAT   = 36,
   parameter int CW        = 6
) (
   input  logic [1:0]    op,
   input  logic [W-1:0]  rs,
   output logic [CW-1:0] lat
);

   logic fast_zero, fast_ones, med_zero, med_ones;
   logic is_fast, is_med;

   // Upper bits all equal means rs fits a narrower two's complement field.
   assign fast_zero = ~|rs[W-1:FAST_BITS];
   assign fast_ones =  &rs[W-1:FAST_BITS];
   assign med_zero  = ~|rs[W-1:MED_BITS];
   assign med_ones  =  &rs[W-1:MED_BITS];

   always_comb begin
      if (op_is_signed(op)) begin
         is_fast = fast_zero | fast_ones;
         is_med  = med_zero  | med_ones;
      end else begin
         is_fast = fast_zero;
         is_med  = med_zero;
      end
   end

   always_comb begin
      if (op_is_div(op))  lat = CW'(DIV_LAT);
      else if (is_fast)   lat = CW'(FAST_LAT);
      else if (is_med)    lat = CW'(MED_LAT);
      else                lat = CW'(SLOW_LAT);
   end

endmodule

// File: rtl/muldiv_arith.sv
module muldiv_arith
   import muldiv_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [1:0]   op,
   input  logic [W-1:0] rs,
   input  logic [W-1:0] rt,
   output logic [W-1:0] res_hi,
   output logic [W-1:0] res_lo
);

   localparam int PW = 2 * W;

   logic          sgn;
   logic [PW-1:0] ext_a, ext_b, prod;
   logic          neg_a, neg_b, div_zero;
   logic [W-1:0]  mag_a, mag_b, safe_b;
   logic [W-1:0]  uq, ur, quo, rem;

   assign sgn = op_is_signed(op);

   // Multiply: extend both operands to double width, keep the low half of the product.
   assign ext_a = {{W{sgn & rs[W-1]}}, rs};
   assign ext_b = {{W{sgn & rt[W-1]}}, rt};
   assign prod  = ext_a * ext_b;

   // Divide: one unsigned divider on magnitudes, signs restored afterwards.
   assign neg_a    = sgn & rs[W-1];
   assign neg_b    = sgn & rt[W-1];
   assign mag_a    = neg_a ? (~rs + 1'b1) : rs;
   assign mag_b    = neg_b ? (~rt + 1'b1) : rt;
   assign div_zero = (rt == '0);
   assign safe_b   = div_zero ? W'(1) : mag_b;
   assign uq       = mag_a / safe_b;
   assign ur       = mag_a % safe_b;
   assign quo      = (neg_a ^ neg_b) ? (~uq + 1'b1) : uq;
   assign rem      = neg_a ? (~ur + 1'b1) : ur;

   always_comb begin
      if (!op_is_div(op)) begin
         res_hi = prod[PW-1:W];
         res_lo = prod[W-1:0];
      end else if (div_zero) begin
         res_hi = rs;
         res_lo = neg_a ? W'(1) : '1;
      end else begin
         res_hi = rem;
         res_lo = quo;
      end
   end

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] lat,
   output logic          busy,
   output logic          last
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b0;
      end else if (start) begin
         cnt  <= lat;
         busy <= 1'b1;
      end else if (busy) begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1)) busy <= 1'b0;
      end
   end

   assign last = busy && (cnt == CW'(1)) && !start;

   // R2 R3 R4: the counter steps down by one per cycle without a new command
   a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && cnt > CW'(1)) |=> (busy && cnt == $past(cnt) - 1'b1));

   // R10: a start pulse always reloads the counter from the new command
   a_r10_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && cnt == $past(lat)));

   // R4: the unit goes idle right after its final cycle
   a_r4_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !busy);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
   import muldiv_pkg::*;
#(
   parameter int W         = 32,
   parameter int FAST_BITS = 11,
   parameter int MED_BITS  = 20,
   parameter int FAST_LAT  = 6,
   parameter int MED_LAT   = 9,
   parameter int SLOW_LAT  = 13,
   parameter int DIV_LAT   = 36
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [1:0]   op_i,
   input  logic [W-1:0] rs_i,
   input  logic [W-1:0] rt_i,
   input  logic         rd_en_i,
   output logic         busy_o,
   output logic         stall_o,
   output logic [W-1:0] hi_o,
   output logic [W-1:0] lo_o
);

   localparam int MAX_LAT = (SLOW_LAT > DIV_LAT) ? SLOW_LAT : DIV_LAT;
   localparam int CW      = $clog2(MAX_LAT + 1);

   if (FAST_BITS >= MED_BITS || MED_BITS >= W || FAST_BITS < 1) begin : g_bad_bits
      $error("muldiv_unit: need 1 <= FAST_BITS < MED_BITS < W");
   end
   if (FAST_LAT < 1 || FAST_LAT > MED_LAT || MED_LAT > SLOW_LAT || DIV_LAT < 1) begin : g_bad_lat
      $error("muldiv_unit: latencies must be positive and ordered fast <= med <= slow");
   end

   logic [CW-1:0] lat;
   logic [W-1:0]  res_hi, res_lo;
   logic [W-1:0]  pend_hi, pend_lo;
   logic [W-1:0]  hi_q, lo_q;
   logic          busy, last;

   muldiv_latency #(
      .W(W), .FAST_BITS(FAST_BITS), .MED_BITS(MED_BITS),
      .FAST_LAT(FAST_LAT), .MED_LAT(MED_LAT), .SLOW_LAT(SLOW_LAT),
      .DIV_LAT(DIV_LAT), .CW(CW)
   ) u_lat (
      .op(op_i), .rs(rs_i), .lat(lat)
   );

   muldiv_arith #(.W(W)) u_arith (
      .op(op_i), .rs(rs_i), .rt(rt_i), .res_hi(res_hi), .res_lo(res_lo)
   );

   muldiv_seq #(.CW(CW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start_i), .lat(lat),
      .busy(busy), .last(last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_hi <= '0;
         pend_lo <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         if (start_i) begin
            pend_hi <= res_hi;
            pend_lo <= res_lo;
         end
         if (last) begin
            hi_q <= pend_hi;
            lo_q <= pend_lo;
         end
      end
   end

   // The final busy cycle forwards the pending result so a waiting read completes there.
   assign hi_o    = last ? pend_hi : hi_q;
   assign lo_o    = last ? pend_lo : lo_q;
   assign stall_o = rd_en_i && busy && !last;
   assign busy_o  = busy;

   // R11: HI/LO change only when an operation retires
   a_r11_hold_hilo: assert property (@(posedge clk) disable iff (!rst_n)
      !last |=> ($stable(hi_q) && $stable(lo_q)));

   // R9: a read granted while busy means the operation retires at this edge
   a_r9_grant_completes: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && busy_o && !stall_o && !start_i) |=> (!busy_o && hi_o == $past(hi_o)));

endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

   localparam int W = 32;

   typedef struct {
      logic [W-1:0] hi;
      logic [W-1:0] lo;
      int           lat;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [1:0]   op_i = '0;
   logic [W-1:0] rs_i = '0;
   logic [W-1:0] rt_i = '0;
   logic         rd_en_i = 1'b0;
   logic         busy_o, stall_o;
   logic [W-1:0] hi_o, lo_o;

   int checks = 0;
   int errors = 0;
   exp_t sb_q[$];
   logic [W-1:0] last_hi = '0, last_lo = '0;

   always #10 clk = ~clk;

   muldiv_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .rs_i(rs_i), .rt_i(rt_i), .rd_en_i(rd_en_i),
      .busy_o(busy_o), .stall_o(stall_o), .hi_o(hi_o), .lo_o(lo_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic int exp_lat(input logic [1:0] op, input logic [W-1:0] a);
      if (op[1]) return 36;
      if (!op[0]) begin
         if (a <= 32'h0000_07FF) return 6;
         if (a <= 32'h000F_FFFF) return 9;
         return 13;
      end
      if (a <= 32'h0000_07FF || a >= 32'hFFFF_F800) return 6;
      if (a <= 32'h000F_FFFF || a >= 32'hFFF0_0000) return 9;
      return 13;
   endfunction

   function automatic exp_t model(input logic [1:0] op, input logic [W-1:0] a,
                                  input logic [W-1:0] b, input string req);
      exp_t e;
      logic [63:0] p;
      e.req = req;
      e.lat = exp_lat(op, a);
      case (op)
         2'd0: begin p = {32'b0, a} * {32'b0, b}; e.hi = p[63:32]; e.lo = p[31:0]; end
         2'd1: begin
            p = 64'(longint'($signed(a)) * longint'($signed(b)));
            e.hi = p[63:32]; e.lo = p[31:0];
         end
         2'd2: begin
            if (b == 0) begin e.hi = a; e.lo = 32'hFFFF_FFFF; end
            else begin e.hi = a % b; e.lo = a / b; end
         end
         default: begin
            if (b == 0) begin e.hi = a; e.lo = a[31] ? 32'h1 : 32'hFFFF_FFFF; end
            else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin e.hi = 0; e.lo = 32'h8000_0000; end
            else begin
               e.hi = 32'($signed(a) % $signed(b));
               e.lo = 32'($signed(a) / $signed(b));
            end
         end
      endcase
      return e;
   endfunction

   // Driver: one start pulse; leaves the bench at the falling edge after it.
   task automatic drive_start(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      start_i = 1'b1; op_i = op; rs_i = a; rt_i = b;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Monitor: hold a read, count stall cycles, pop and compare at the grant.
   task automatic monitor_pop();
      exp_t e;
      int stalls = 0;
      rd_en_i = 1'b1;
      #1;
      while (stall_o && stalls < 100) begin
         stalls++;
         @(negedge clk);
         #1;
      end
      e = sb_q.pop_front();
      chk({e.req, " R9"}, "stall cycles", W'(stalls), W'(e.lat - 1));
      chk({e.req, " R9"}, "hi at grant", hi_o, e.hi);
      chk({e.req, " R9"}, "lo at grant", lo_o, e.lo);
      last_hi = e.hi; last_lo = e.lo;
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic run(input logic [1:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string req);
      sb_q.push_back(model(op, a, b, req));
      drive_start(op, a, b);
      monitor_pop();
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rd_en_i = 1'b1;
      #1;
      // R1: reset state, read held during reset
      chk("R1", "busy", W'(busy_o), 0);
      chk("R1", "stall", W'(stall_o), 0);
      chk("R1", "hi", hi_o, 0);
      chk("R1", "lo", lo_o, 0);
      @(negedge clk);
      rd_en_i = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      // R2 unsigned multiply latency boundaries, R5 products
      run(2'd0, 32'h0000_07FF, 32'h0000_0003, "R2 R5");
      run(2'd0, 32'h0000_0800, 32'h1234_5678, "R2 R5");
      run(2'd0, 32'h000F_FFFF, 32'h0000_0010, "R2");
      run(2'd0, 32'h0010_0000, 32'hFFFF_FFFF, "R2 R5");
      run(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 R5");
      // R3 signed multiply latency boundaries, R5 signed products
      run(2'd1, 32'hFFFF_F800, 32'h0000_0005, "R3 R5");
      run(2'd1, 32'h0000_07FF, 32'hFFFF_FFFD, "R3 R5");
      run(2'd1, 32'hFFFF_F7FF, 32'hFFFF_FFFD, "R3 R5");
      run(2'd1, 32'hFFF0_0000, 32'h0000_0100, "R3");
      run(2'd1, 32'h0000_0800, 32'h0000_0002, "R3");
      run(2'd1, 32'hFFEF_FFFF, 32'h0000_0007, "R3 R5");
      run(2'd1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 R5");
      // R4 fixed divide latency, R6 quotient/remainder signs
      run(2'd2, 32'd100, 32'd7, "R4 R6");
      run(2'd2, 32'hFFFF_FFFF, 32'h0000_0010, "R4 R6");
      run(2'd3, 32'hFFFF_FF9C, 32'd7, "R4 R6");
      run(2'd3, 32'd100, 32'hFFFF_FFF9, "R4 R6");
      // R7 divide by zero
      run(2'd2, 32'h8765_4321, 32'h0, "R7");
      run(2'd3, 32'hFFFF_FFFB, 32'h0, "R7");
      run(2'd3, 32'h0000_0005, 32'h0, "R7");
      // R8 signed overflow
      run(2'd3, 32'h8000_0000, 32'hFFFF_FFFF, "R8");

      // R10: abandon a slow multiply three cycles in, then divide
      drive_start(2'd0, 32'hFFFF_FFFF, 32'h0000_0002);
      repeat (2) @(negedge clk);
      sb_q.push_back(model(2'd2, 32'd1000, 32'd9, "R10"));
      drive_start(2'd2, 32'd1000, 32'd9);
      monitor_pop();

      // R11: idle reads neither stall nor alter HI/LO
      repeat (4) @(negedge clk);
      rd_en_i = 1'b1;
      for (int i = 0; i < 3; i++) begin
         #1;
         chk("R11", "idle stall", W'(stall_o), 0);
         chk("R11", "idle hi", hi_o, last_hi);
         chk("R11", "idle lo", lo_o, last_lo);
         @(negedge clk);
      end
      rd_en_i = 1'b0;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule